// File: doc/BRIEF.md
# Bit-Field Insert Unit

This unit writes a run of low-order bits from a 64-bit source word into a 64-bit destination word. The run begins at a chosen bit position, and every destination bit outside the run keeps its old value. Two 6-bit controls set the operation: a field length and a bit index. They come either from two 8-bit immediate control bytes or from fixed slots in the upper half of a 128-bit source register. A select input picks which of the two is used, per transfer.

The unit is one registered pipeline stage with valid/ready handshakes on both sides. An input transfer happens on a rising clock edge when `in_valid_i` and `in_ready_o` are both high. The result shows up on the output one clock later. The stage holds its output, unchanged, for as long as `out_valid_o` is high and `out_ready_i` is low. The input is ready when the stage is empty or its content leaves in the same cycle (`in_ready_o = !out_valid_o || out_ready_i`).

A length code of zero stands for a full 64-bit field. When index plus effective length goes past 64, the operation is undefined. The unit still produces a defined value in that case and raises a flag beside it.

Top module: `insq_unit`

## Requirements
- R1: For an effective length L and index I with I+L ≤ 64, result bits I+L-1..I equal source bits L-1..0. For example, I=32 and L=16 places source bits 15..0 at result bits 47..32.
- R2: Every bit of result[63:0] outside the inserted field equals the matching destination bit.
- R3: A length code of 0 means L=64. With index 0 this makes result[63:0] equal to the whole low source word.
- R4: Only bits 5..0 of each control byte, or of each register control slot, are used. Control-byte bits 7..6 have no effect. Source bits 71:70 and 79:78 have no effect.
- R5: When form_sel_i=0 (immediate form), the length is imm_len_i[5:0] and the index is imm_idx_i[5:0].
- R6: When form_sel_i=1 (register form), the index is src_i[77:72] and the length is src_i[69:64]. The immediate bytes have no effect in this form.
- R7: undefined_o is 1 exactly when I+L > 64, including length code 0 with a nonzero index. In that case result[63:0] is still (dst AND NOT M) OR ((src<<I) AND M), where M is the all-ones L-bit mask shifted left by I and truncated to 64 bits.
- R8: result_o[127:64] is always zero.
- R9: A transfer accepted at one edge sets out_valid_o at the next edge, and the result and flag appear with it. A synchronous reset clears out_valid_o, and in_ready_o is 1 while the stage is empty.
- R10: While out_valid_o=1 and out_ready_i=0, in_ready_o=0, and out_valid_o, result_o and undefined_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input transfer offered |
| in_ready_o | output | 1 | Stage can take an input transfer |
| form_sel_i | input | 1 | 0: controls from immediate bytes, 1: controls from source register |
| dst_i | input | 64 | Destination word to merge into |
| src_i | input | 128 | Source register; data in bits 63:0, register-form controls above |
| imm_len_i | input | 8 | Immediate length byte |
| imm_idx_i | input | 8 | Immediate index byte |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Downstream accepts result |
| result_o | output | 128 | Merged word in 63:0, zero above |
| undefined_o | output | 1 | Index plus length exceeded 64 for this result |

## Verification
The embedded assertions check the following on every cycle:
- A defined control pair gives a mask whose population equals the effective length, and length 0 with index 0 gives a full mask.
- The merge never alters destination bits outside the mask.
- An accepted input always becomes a valid output on the next edge, and reset empties the stage.
- A stalled output holds steady.

Only the bench's sweeps can show the data-dependent content of the result. The bench runs every length/index pair in both forms, with the ignored control bits scrambled. It also covers the zeroed upper half, the exact point where the overflow flag turns on, and the hand-off of a new input when a stall is released.

// File: rtl/insq_pkg.sv
package insq_pkg;
  localparam int unsigned WORD_W_DEF = 64;
  localparam int unsigned IMM_W_DEF  = 8;
  localparam int unsigned LEN_LSB_DEF = 64;
  localparam int unsigned IDX_LSB_DEF = 72;

  typedef enum logic {
    FORM_IMM = 1'b0,
    FORM_REG = 1'b1
  } form_e;
endpackage

// File: rtl/insq_ctrl_sel.sv
module insq_ctrl_sel
  import insq_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned IMM_W   = IMM_W_DEF,
  parameter int unsigned LEN_LSB = LEN_LSB_DEF,
  parameter int unsigned IDX_LSB = IDX_LSB_DEF,
  localparam int unsigned CTRL_W = $clog2(WORD_W)
) (
  input  logic              form_sel,
  input  logic [IMM_W-1:0]  imm_len,
  input  logic [IMM_W-1:0]  imm_idx,
  input  logic [CTRL_W-1:0] reg_len,
  input  logic [CTRL_W-1:0] reg_idx,
  output logic [CTRL_W-1:0] len,
  output logic [CTRL_W-1:0] idx
);
  form_e form;
  logic  unused_imm_hi;

  assign form = form_e'(form_sel);
  assign unused_imm_hi = ^{imm_len[IMM_W-1:CTRL_W], imm_idx[IMM_W-1:CTRL_W]};

  always_comb begin
    unique case (form)
      FORM_REG: begin
        len = reg_len;
        idx = reg_idx;
      end
      default: begin
        len = imm_len[CTRL_W-1:0];
        idx = imm_idx[CTRL_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/insq_mask_gen.sv
module insq_mask_gen #(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned CTRL_W = $clog2(WORD_W),
  localparam int unsigned SUM_W  = CTRL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] len,
  input  logic [CTRL_W-1:0] idx,
  output logic [WORD_W-1:0] mask,
  output logic              overflow
);
  logic [SUM_W-1:0] eff_len;
  logic [SUM_W-1:0] lo_bound;
  logic [SUM_W-1:0] hi_bound;

  assign eff_len  = (len == '0) ? SUM_W'(WORD_W) : SUM_W'(len);
  assign lo_bound = SUM_W'(idx);
  assign hi_bound = lo_bound + eff_len;
  assign overflow = hi_bound > SUM_W'(WORD_W);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign mask[b] = (SUM_W'(b) >= lo_bound) && (SUM_W'(b) < hi_bound);
  end

  // R3, R7
  mask_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !overflow |-> ($countones(mask) == int'(eff_len)));

  // R3
  full_word_chk: assert property (@(posedge clk) disable iff (rst)
    (len == '0 && idx == '0) |-> (mask == '1));
endmodule

// File: rtl/insq_merge.sv
module insq_merge #(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned CTRL_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] src_lo,
  input  logic [CTRL_W-1:0] idx,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] merged
);
  logic [WORD_W-1:0] shifted;

  assign shifted = src_lo << idx;
  assign merged  = (dst & ~mask) | (shifted & mask);

  // R2
  keep_dst_chk: assert property (@(posedge clk) disable iff (rst)
    ((merged ^ dst) & ~mask) == '0);
endmodule

// File: rtl/insq_unit.sv
module insq_unit
  import insq_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned IMM_W   = IMM_W_DEF,
  parameter int unsigned LEN_LSB = LEN_LSB_DEF,
  parameter int unsigned IDX_LSB = IDX_LSB_DEF,
  localparam int unsigned CTRL_W = $clog2(WORD_W),
  localparam int unsigned REG_W  = 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             form_sel_i,
  input  logic [WORD_W-1:0] dst_i,
  input  logic [REG_W-1:0]  src_i,
  input  logic [IMM_W-1:0]  imm_len_i,
  input  logic [IMM_W-1:0]  imm_idx_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [REG_W-1:0]  result_o,
  output logic             undefined_o
);
  logic [CTRL_W-1:0] len_sel, idx_sel;
  logic [WORD_W-1:0] mask, merged, res_q;
  logic              overflow, undef_q, vld_q;
  logic              unused_src_hi;

  assign unused_src_hi = ^src_i[REG_W-1:WORD_W];

  insq_ctrl_sel #(
    .WORD_W(WORD_W), .IMM_W(IMM_W), .LEN_LSB(LEN_LSB), .IDX_LSB(IDX_LSB)
  ) u_ctrl (
    .form_sel(form_sel_i),
    .imm_len (imm_len_i),
    .imm_idx (imm_idx_i),
    .reg_len (src_i[LEN_LSB +: CTRL_W]),
    .reg_idx (src_i[IDX_LSB +: CTRL_W]),
    .len     (len_sel),
    .idx     (idx_sel)
  );

  insq_mask_gen #(.WORD_W(WORD_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .len     (len_sel),
    .idx     (idx_sel),
    .mask    (mask),
    .overflow(overflow)
  );

  insq_merge #(.WORD_W(WORD_W)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .dst   (dst_i),
    .src_lo(src_i[WORD_W-1:0]),
    .idx   (idx_sel),
    .mask  (mask),
    .merged(merged)
  );

  assign in_ready_o = !vld_q || out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      undef_q <= 1'b0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        res_q   <= merged;
        undef_q <= overflow;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = {{WORD_W{1'b0}}, res_q};
  assign undefined_o = undef_q;

  // R9
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  // R9
  reset_empty_chk: assert property (@(posedge clk)
    rst |=> !out_valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(result_o) && $stable(undefined_o)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
endmodule

// File: tb/insq_unit_tb.sv
`timescale 1ns/1ps
module insq_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic         form_sel_i = 1'b0;
  logic [63:0]  dst_i = '0;
  logic [127:0] src_i = '0;
  logic [7:0]   imm_len_i = '0;
  logic [7:0]   imm_idx_i = '0;
  logic         out_valid_o;
  logic         out_ready_i = 1'b1;
  logic [127:0] result_o;
  logic         undefined_o;

  int vectors = 0;
  int fails   = 0;
  logic [63:0] seed = 64'h0f1e_2d3c_4b5a_6978;

  always #2.5 clk = ~clk;

  insq_unit u_dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .form_sel_i(form_sel_i), .dst_i(dst_i), .src_i(src_i),
    .imm_len_i(imm_len_i), .imm_idx_i(imm_idx_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .result_o(result_o), .undefined_o(undefined_o)
  );

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [63:0] model(logic [63:0] d, logic [63:0] s, int i, int l);
    int eff = (l == 0) ? 64 : l;
    logic [127:0] ones = (128'd1 << eff) - 128'd1;
    logic [127:0] m128 = ones << i;
    logic [63:0]  m = m128[63:0];
    return (d & ~m) | ((s << i) & m);
  endfunction

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic run_vec(string req, logic form, logic [63:0] d, logic [127:0] s,
                         logic [7:0] il, logic [7:0] ii, int i, int l);
    int eff = (l == 0) ? 64 : l;
    form_sel_i = form; dst_i = d; src_i = s;
    imm_len_i = il; imm_idx_i = ii; in_valid_i = 1'b1;
    @(negedge clk);
    chk({req, " result"}, result_o, {64'h0, model(d, s[63:0], i, l)});
    chk("R7 undefined flag", {127'h0, undefined_o}, {127'h0, (i + eff) > 64});
    chk("R9 out_valid one cycle later", {127'h0, out_valid_o}, 128'h1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL R9 watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] s;
    logic [63:0]  r;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset out_valid", {127'h0, out_valid_o}, 128'h0);
    chk("R9 reset in_ready", {127'h0, in_ready_o}, 128'h1);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle out_valid", {127'h0, out_valid_o}, 128'h0);

    // R1 R2 R3 R4 R5 R7 R8: immediate form, every pair, junk in ignored bits
    for (int i = 0; i < 64; i++) begin
      for (int l = 0; l < 64; l++) begin
        r = rnd();
        s = {rnd(), rnd()};
        run_vec("R1/R2/R5/R8 imm", 1'b0, rnd(), s,
                {r[7:6], 6'(l)}, {r[15:14], 6'(i)}, i, l);
      end
    end

    // R1 R2 R3 R4 R6 R7 R8: register form, every pair, junk in 71:70, 79:78 and imm bytes
    for (int i = 0; i < 64; i++) begin
      for (int l = 0; l < 64; l++) begin
        r = rnd();
        s = {rnd(), rnd()};
        s[69:64] = 6'(l);
        s[77:72] = 6'(i);
        run_vec("R4/R6 reg", 1'b1, rnd(), s, r[7:0], r[15:8], i, l);
      end
    end

    // R1: worked example, index 32 length 16
    run_vec("R1 example", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF,
            {64'h0, 64'h1234_5678_9ABC_DEF0}, 8'd16, 8'd32, 32, 16);
    chk("R1 example literal", result_o, {64'h0, 64'hFFFF_DEF0_FFFF_FFFF});

    // R3: length 0 index 0 copies whole source word
    run_vec("R3 full copy", 1'b0, 64'hAAAA_5555_AAAA_5555,
            {64'hDEAD, 64'h0123_4567_89AB_CDEF}, 8'd0, 8'd0, 0, 0);
    chk("R3 full copy literal", result_o, {64'h0, 64'h0123_4567_89AB_CDEF});

    // R7: boundary, index 48 length 16 defined; index 48 length 17 undefined
    run_vec("R7 edge defined", 1'b0, rnd(), {rnd(), rnd()}, 8'd16, 8'd48, 48, 16);
    run_vec("R7 edge overflow", 1'b0, rnd(), {rnd(), rnd()}, 8'd17, 8'd48, 48, 17);
    chk("R7 flag set", {127'h0, undefined_o}, 128'h1);

    // R10: stall holds output and blocks input
    run_vec("R10 pre-stall", 1'b0, 64'h0, {64'h0, 64'hFF}, 8'd8, 8'd4, 4, 8);
    held = result_o;
    out_ready_i = 1'b0;
    form_sel_i = 1'b0; dst_i = 64'h0; src_i = {64'h0, 64'h3};
    imm_len_i = 8'd2; imm_idx_i = 8'd60; in_valid_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 stalled valid", {127'h0, out_valid_o}, 128'h1);
      chk("R10 stalled result", result_o, held);
      chk("R10 stalled in_ready", {127'h0, in_ready_o}, 128'h0);
    end
    out_ready_i = 1'b1;
    @(negedge clk);
    chk("R10 released result", result_o, {64'h0, 64'h3000_0000_0000_0000});

    // R9: reset while full empties the stage
    rst = 1'b1;
    in_valid_i = 1'b0;
    @(negedge clk);
    chk("R9 mid reset out_valid", {127'h0, out_valid_o}, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 post reset idle", {127'h0, out_valid_o}, 128'h0);

    summary();
    $finish;
  end
endmodule